// File: doc/BRIEF.md
# Modifier-Qualified RAM Window Slave

This block is the slave port of a board that sits on an asynchronous, strobe-handshaked backplane and exposes a local dual-port RAM to bus masters. A cycle is taken only when the master presents one of four accepted address-modifier codes and an address inside this board's window. The window is chosen by a 3-bit board-identity jumper, so up to eight identical boards can share one backplane, each answering its own 64 KiB slice.

The address strobe and data strobe are brought into the local clock through two-flop synchronizers. A falling address strobe, once synchronized, starts decoding. The block then waits for the data strobe and performs one RAM write or read as the write line directs. It pulls the data acknowledge low and holds it until the data strobe has been released. The read data drivers are enabled only while the acknowledged read is in progress and the data strobe is still low. Each fall of the address strobe can yield at most one acknowledge.

Top module: `vslv_top`

## Requirements
- R1: While `rst` is high and on the first sampled cycle after it, `bus_dtack_n` is 1, `bus_drv_en` is 0, and `ram_we` and `ram_re` are both 0.
- R2: A cycle is accepted only when `bus_am` equals 6'b111110, 6'b111001, 6'b111101 or 6'b111010. Any other code gives no acknowledge and no RAM access.
- R3: A cycle is accepted only when `bus_addr[31:20]` is 12'hFE1, `bus_addr[19]` is 0 and `bus_addr[18:16]` equals `board_id`. Other addresses give no acknowledge and no RAM access.
- R4: With `bus_write_n` low, an accepted cycle gives exactly one single-cycle `ram_we` pulse. On that pulse `ram_addr` is `bus_addr[8:1]` and `ram_wdata` is the bus write data. `ram_we` and `ram_re` are never high together.
- R5: With `bus_write_n` high, an accepted cycle issues one `ram_re`. The RAM returns data one clock later, and that word is presented on `bus_rdata` while the acknowledge is low.
- R6: `bus_dtack_n` stays high until the data strobe has gone low. After the data strobe is released, `bus_dtack_n` returns high within 4 clock cycles.
- R7: `bus_drv_en` is high only during an acknowledged read while the data strobe is low, and never during a write. `bus_rdata` is zero whenever `bus_drv_en` is low.
- R8: Holding the address strobe low after a completed cycle produces no second acknowledge and no further RAM access.
- R9: If the address strobe is released before the data strobe falls, the cycle is dropped with no acknowledge and no RAM access, and the next cycle is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| board_id | input | 3 | Board-identity jumper selecting the window |
| bus_am | input | 6 | Address-modifier code |
| bus_addr | input | 32 | Bus byte address |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_ds_n | input | 1 | Data strobe, active low |
| bus_write_n | input | 1 | Low for master-to-slave write |
| bus_wdata | input | 16 | Data from the bus |
| bus_rdata | output | 16 | Data toward the bus |
| bus_drv_en | output | 1 | Enable for the bus data drivers |
| bus_dtack_n | output | 1 | Data acknowledge, active low |
| ram_addr | output | 8 | RAM word address |
| ram_we | output | 1 | RAM write pulse |
| ram_re | output | 1 | RAM read request |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data, one cycle after `ram_re` |

## Verification
The hardest cases to reach are the ones where the strobes do not follow the textbook order. In one, the address strobe stays low after the data strobe is released, so the block sits idle with a low synchronized strobe and must not start again. In the other, the address strobe is withdrawn before any data strobe. A single directed cycle task takes a flag to hold the address strobe and a gap before the data strobe. These reach both cases from the ports, and a count of RAM-side accesses shows that nothing was touched. The same gap shows that no acknowledge comes early.

// File: rtl/vslv_pkg.sv
package vslv_pkg;

    localparam int AM_W   = 6;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 16;
    localparam int N_AM   = 4;

    localparam logic [AM_W-1:0] AM_ACCEPT [N_AM] = '{
        6'b111110, 6'b111001, 6'b111101, 6'b111010
    };

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_XFER,
        ST_RDWAIT,
        ST_ACK
    } vslv_state_e;

    typedef struct packed {
        logic              is_write;
        logic [DATA_W-1:0] wdata;
        logic [ADDR_W-1:0] addr;
    } vslv_req_t;

endpackage

// File: rtl/vslv_sync.sv
module vslv_sync #(
    parameter int   N       = 2,
    parameter logic RST_LVL = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d_in,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic st1, st2;
        always_ff @(posedge clk) begin
            if (rst) begin
                st1 <= RST_LVL;
                st2 <= RST_LVL;
            end else begin
                st1 <= d_in[i];
                st2 <= st1;
            end
        end
        assign q[i] = st2;
    end
endmodule

// File: rtl/vslv_decode.sv
module vslv_decode
    import vslv_pkg::*;
#(
    parameter int               ID_W     = 3,
    parameter int               SLICE_LSB = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'hFE10_0000
) (
    input  logic [AM_W-1:0]   am,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ID_W-1:0]   board_id,
    output logic              hit
);
    localparam int FLD_W   = ID_W + 1;
    localparam int TAG_LSB = SLICE_LSB + FLD_W;

    logic [N_AM-1:0] am_match;
    for (genvar i = 0; i < N_AM; i++) begin : g_am
        assign am_match[i] = (am == AM_ACCEPT[i]);
    end

    logic tag_ok, slice_ok;
    assign tag_ok   = (addr[ADDR_W-1:TAG_LSB] == WIN_BASE[ADDR_W-1:TAG_LSB]);
    assign slice_ok = (addr[SLICE_LSB +: FLD_W] == {1'b0, board_id});
    assign hit      = (|am_match) && tag_ok && slice_ok;
endmodule

// File: rtl/vslv_fsm.sv
module vslv_fsm
    import vslv_pkg::*;
#(
    parameter int RAM_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              as_s,
    input  logic              ds_s,
    input  logic              hit,
    input  vslv_req_t         req_in,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_we,
    output logic              ram_re,
    output logic [DATA_W-1:0] ram_wdata,
    output logic [DATA_W-1:0] rd_word,
    output logic              drv_en,
    output logic              dtack_n
);
    vslv_state_e state, nxt;
    vslv_req_t   req_q;
    logic        as_prev;
    logic        as_fall;

    assign as_fall = as_prev && !as_s;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:   if (as_fall && hit) nxt = ST_SEL;
            ST_SEL:    if (as_s) nxt = ST_IDLE;
                       else if (!ds_s) nxt = ST_XFER;
            ST_XFER:   nxt = req_q.is_write ? ST_ACK : ST_RDWAIT;
            ST_RDWAIT: nxt = ST_ACK;
            ST_ACK:    if (ds_s) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            as_prev <= 1'b1;
            req_q   <= '0;
            rd_word <= '0;
        end else begin
            state   <= nxt;
            as_prev <= as_s;
            if (state == ST_IDLE && as_fall && hit) req_q <= req_in;
            if (state == ST_SEL && !as_s && !ds_s) req_q.wdata <= bus_wdata;
            if (state == ST_RDWAIT) rd_word <= ram_rdata;
        end
    end

    assign ram_addr  = req_q.addr[RAM_AW:1];
    assign ram_wdata = req_q.wdata;
    assign ram_we    = (state == ST_XFER) && req_q.is_write;
    assign ram_re    = (state == ST_XFER) && !req_q.is_write;
    assign dtack_n   = (state != ST_ACK);
    assign drv_en    = (state == ST_ACK) && !req_q.is_write && !ds_s;

    p_we_re_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(ram_we && ram_re));

    p_we_single_r4: assert property (@(posedge clk) disable iff (rst)
        ram_we |=> !ram_we);

    p_ack_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (!dtack_n && ds_s) |=> dtack_n);

    p_ack_from_access_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(dtack_n) |-> ($past(ram_we) || $past(ram_re, 2)));
endmodule

// File: rtl/vslv_top.sv
module vslv_top
    import vslv_pkg::*;
#(
    parameter int               ID_W     = 3,
    parameter int               RAM_AW   = 8,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'hFE10_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ID_W-1:0]   board_id,
    input  logic [AM_W-1:0]   bus_am,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_as_n,
    input  logic              bus_ds_n,
    input  logic              bus_write_n,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_drv_en,
    output logic              bus_dtack_n,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_we,
    output logic              ram_re,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata
);
    localparam int SLICE_LSB = 16;

    logic [1:0]        strobe_s;
    logic              hit;
    logic [DATA_W-1:0] rd_word;
    vslv_req_t         req_in;

    vslv_sync #(.N(2), .RST_LVL(1'b1)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .d_in ({bus_ds_n, bus_as_n}),
        .q    (strobe_s)
    );

    vslv_decode #(.ID_W(ID_W), .SLICE_LSB(SLICE_LSB), .WIN_BASE(WIN_BASE)) u_dec (
        .am       (bus_am),
        .addr     (bus_addr),
        .board_id (board_id),
        .hit      (hit)
    );

    assign req_in = '{is_write: !bus_write_n, wdata: bus_wdata, addr: bus_addr};

    vslv_fsm #(.RAM_AW(RAM_AW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .as_s      (strobe_s[0]),
        .ds_s      (strobe_s[1]),
        .hit       (hit),
        .req_in    (req_in),
        .bus_wdata (bus_wdata),
        .ram_rdata (ram_rdata),
        .ram_addr  (ram_addr),
        .ram_we    (ram_we),
        .ram_re    (ram_re),
        .ram_wdata (ram_wdata),
        .rd_word   (rd_word),
        .drv_en    (bus_drv_en),
        .dtack_n   (bus_dtack_n)
    );

    assign bus_rdata = bus_drv_en ? rd_word : '0;

    p_drv_read_ack_r7: assert property (@(posedge clk) disable iff (rst)
        bus_drv_en |-> (!bus_dtack_n && bus_write_n));

    p_rdata_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !bus_drv_en |-> (bus_rdata == '0));
endmodule

// File: tb/tb_vslv_top.sv
module tb_vslv_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  board_id = 3'd2;
    logic [5:0]  bus_am = 6'h00;
    logic [31:0] bus_addr = '0;
    logic        bus_as_n = 1'b1;
    logic        bus_ds_n = 1'b1;
    logic        bus_write_n = 1'b1;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_drv_en, bus_dtack_n;
    logic [7:0]  ram_addr;
    logic        ram_we, ram_re;
    logic [15:0] ram_wdata;
    logic [15:0] ram_rdata = '0;

    int total = 0;
    int bad = 0;
    int acc_cnt = 0;
    int we_cnt = 0;
    logic [7:0]  last_we_addr;
    logic [15:0] last_we_data;
    logic [15:0] mem [256];
    int  last_rel;
    bit  reack;
    bit  done = 0;

    always #10 clk = ~clk;

    vslv_top dut (
        .clk(clk), .rst(rst), .board_id(board_id), .bus_am(bus_am),
        .bus_addr(bus_addr), .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n),
        .bus_write_n(bus_write_n), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_drv_en(bus_drv_en), .bus_dtack_n(bus_dtack_n), .ram_addr(ram_addr),
        .ram_we(ram_we), .ram_re(ram_re), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0101) ^ 16'h5A00;
    end

    always @(posedge clk) begin
        if (ram_we) begin
            mem[ram_addr] <= ram_wdata;
            we_cnt        <= we_cnt + 1;
            last_we_addr  <= ram_addr;
            last_we_data  <= ram_wdata;
        end
        if (ram_re) ram_rdata <= mem[ram_addr];
        if (ram_we || ram_re) acc_cnt <= acc_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_cycle(input logic [5:0] am, input logic [31:0] addr,
                             input bit wr, input logic [15:0] wd,
                             input int ds_gap, input bit hold_as, input bit abort,
                             output bit acked, output logic [15:0] rd,
                             output bit drv_seen, output bit early_ack);
        acked = 0; rd = '0; drv_seen = 0; early_ack = 0; last_rel = -1; reack = 0;
        @(negedge clk);
        bus_am = am; bus_addr = addr; bus_write_n = !wr; bus_wdata = wd;
        @(negedge clk);
        bus_as_n = 1'b0;
        for (int g = 0; g < ds_gap; g++) begin
            @(negedge clk);
            if (!bus_dtack_n) early_ack = 1;
            if (bus_drv_en) drv_seen = 1;
        end
        if (abort) begin
            bus_as_n = 1'b1;
            for (int g = 0; g < 4; g++) @(negedge clk);
            bus_ds_n = 1'b0;
            for (int g = 0; g < 8; g++) begin
                @(negedge clk);
                if (!bus_dtack_n) acked = 1;
            end
            bus_ds_n = 1'b1;
            for (int g = 0; g < 4; g++) @(negedge clk);
            return;
        end
        bus_ds_n = 1'b0;
        for (int k = 0; k < 20 && !acked; k++) begin
            @(negedge clk);
            if (bus_drv_en) begin drv_seen = 1; rd = bus_rdata; end
            if (!bus_dtack_n) acked = 1;
        end
        bus_ds_n = 1'b1;
        if (acked) begin
            for (int k = 1; k <= 8 && last_rel < 0; k++) begin
                @(negedge clk);
                if (bus_drv_en && !bus_ds_n) drv_seen = 1;
                if (bus_dtack_n) last_rel = k;
            end
        end
        if (hold_as) begin
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (!bus_dtack_n) reack = 1;
            end
        end
        bus_as_n = 1'b1;
        for (int k = 0; k < 4; k++) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(bus_dtack_n === 1'b1, "R1", "dtack_n in reset", bus_dtack_n, 1);
        chk(bus_drv_en === 1'b0 && ram_we === 1'b0 && ram_re === 1'b0, "R1",
            "drv/we/re in reset", {bus_drv_en, ram_we, ram_re}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(bus_dtack_n === 1'b1 && bus_drv_en === 1'b0, "R1", "after reset",
            {bus_dtack_n, bus_drv_en}, 2'b10);
    endtask

    task automatic t_write_read_codes();
        logic [5:0] codes [4] = '{6'b111110, 6'b111001, 6'b111101, 6'b111010};
        bit a, d, e; logic [15:0] r;
        for (int i = 0; i < 4; i++) begin
            int w0;
            logic [31:0] ad;
            logic [15:0] dv;
            ad = 32'hFE12_0000 | 32'(i * 34 + 6);
            dv = 16'hC300 + 16'(i * 7);
            w0 = we_cnt;
            bus_cycle(codes[i], ad, 1'b1, dv, 1, 0, 0, a, r, d, e);
            chk(a, "R2", "write ack for accepted code", a, 1);
            chk(we_cnt == w0 + 1, "R4", "one write pulse", we_cnt - w0, 1);
            chk(last_we_addr == ad[8:1] && last_we_data == dv, "R4", "write addr/data",
                {last_we_addr, last_we_data}, {ad[8:1], dv});
            chk(!d, "R7", "no drive during write", d, 0);
            chk(last_rel >= 1 && last_rel <= 4, "R6", "ack release latency", last_rel, 3);
            bus_cycle(codes[i], ad, 1'b0, 16'h0, 1, 0, 0, a, r, d, e);
            chk(a && d, "R5", "read acked and driven", {a, d}, 2'b11);
            chk(r == dv, "R5", "read data", r, dv);
            @(negedge clk);
            chk(!bus_drv_en && bus_rdata == 16'h0, "R7", "rdata quiet after read",
                bus_rdata, 0);
        end
        bus_cycle(6'b111101, 32'hFE12_0000 | 32'd200, 1'b0, 16'h0, 2, 0, 0, a, r, d, e);
        chk(a && r == (16'(100 * 16'h0101) ^ 16'h5A00), "R5", "read of untouched word",
            r, 16'(100 * 16'h0101) ^ 16'h5A00);
    endtask

    task automatic t_bad_codes();
        logic [5:0] bads [5] = '{6'b111111, 6'b001001, 6'b101101, 6'b000000, 6'b111011};
        bit a, d, e; logic [15:0] r;
        for (int i = 0; i < 5; i++) begin
            int c0 = acc_cnt;
            bus_cycle(bads[i], 32'hFE12_0010, 1'b1, 16'hDEAD, 1, 0, 0, a, r, d, e);
            chk(!a && acc_cnt == c0, "R2", "rejected code", {a, 8'(acc_cnt - c0)}, 0);
        end
    endtask

    task automatic t_window();
        logic [31:0] misses [4] = '{32'hFE13_0010, 32'hFE1A_0010, 32'hFE22_0010,
                                    32'h0012_0010};
        bit a, d, e; logic [15:0] r;
        for (int i = 0; i < 4; i++) begin
            int c0 = acc_cnt;
            bus_cycle(6'b111110, misses[i], 1'b1, 16'hBEEF, 1, 0, 0, a, r, d, e);
            chk(!a && acc_cnt == c0, "R3", "outside window", misses[i], 0);
        end
        board_id = 3'd7;
        bus_cycle(6'b111001, 32'hFE17_0020, 1'b1, 16'h7777, 1, 0, 0, a, r, d, e);
        chk(a && last_we_addr == 8'h10, "R3", "board 7 window", last_we_addr, 8'h10);
        bus_cycle(6'b111001, 32'hFE17_0020, 1'b0, 16'h0, 1, 0, 0, a, r, d, e);
        chk(a && r == 16'h7777, "R3", "board 7 readback", r, 16'h7777);
        begin
            int c0 = acc_cnt;
            bus_cycle(6'b111001, 32'hFE12_0020, 1'b1, 16'h1111, 1, 0, 0, a, r, d, e);
            chk(!a && acc_cnt == c0, "R3", "old slice after id change", a, 0);
        end
        board_id = 3'd2;
    endtask

    task automatic t_ds_delay();
        bit a, d, e; logic [15:0] r;
        bus_cycle(6'b111010, 32'hFE12_0040, 1'b1, 16'h4242, 10, 0, 0, a, r, d, e);
        chk(!e, "R6", "no ack before data strobe", e, 0);
        chk(a && last_rel >= 1 && last_rel <= 4, "R6", "ack then release",
            last_rel, 3);
    endtask

    task automatic t_hold_as();
        bit a, d, e; logic [15:0] r;
        int c0;
        bus_cycle(6'b111110, 32'hFE12_0050, 1'b1, 16'h5151, 1, 1, 0, a, r, d, e);
        c0 = acc_cnt;
        chk(a, "R8", "first ack", a, 1);
        chk(!reack, "R8", "no second ack while strobe held", reack, 0);
        bus_cycle(6'b111110, 32'hFE12_0050, 1'b0, 16'h0, 1, 0, 0, a, r, d, e);
        chk(acc_cnt == c0 + 1 && r == 16'h5151, "R8", "single access per strobe",
            acc_cnt - c0, 1);
    endtask

    task automatic t_abort();
        bit a, d, e; logic [15:0] r;
        int c0 = acc_cnt;
        bus_cycle(6'b111110, 32'hFE12_0060, 1'b1, 16'h9999, 5, 0, 1, a, r, d, e);
        chk(!a && acc_cnt == c0, "R9", "abandoned cycle", {a, 8'(acc_cnt - c0)}, 0);
        bus_cycle(6'b111110, 32'hFE12_0060, 1'b1, 16'h6060, 1, 0, 0, a, r, d, e);
        chk(a && last_we_data == 16'h6060, "R9", "next cycle served", last_we_data,
            16'h6060);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_write_read_codes();
        t_bad_codes();
        t_window();
        t_ds_delay();
        t_hold_as();
        t_abort();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule